// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two 32-bit integers over a fixed number of clock cycles and returns the full 64-bit product as an upper word and a lower word. It keeps a single 64-bit product register. The lower half of that register is first loaded with the multiplier operand, and one 32-bit adder updates only the upper half. Each step looks at the low end of the register, adds the multiplicand into the upper half, subtracts it, or leaves it alone, and then shifts the whole register right by one place. Result bits leave the adder's reach as they settle, and multiplier bits are used up from the bottom.

A mode input picks the interpretation. In unsigned mode the step adds whenever the register's lowest bit is set, and the adder's carry becomes the new top bit. In signed mode the step recodes the lowest bit together with the bit shifted out on the previous step (Booth recoding) and shifts arithmetically, which gives a two's-complement product on the same adder. A caller pulses `start` with the operands while the block is idle, waits for the one-cycle `done` pulse, and then reads the result. The result holds until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy`, `done`, `hi` and `lo` are all 0.
- R2: A `start` sampled high while `busy` is low is accepted, and `busy` is high from the following cycle.
- R3: `done` is high for exactly one cycle, 32 cycles after the accepting edge, and `busy` falls in the same cycle.
- R4: In unsigned mode (`signedMode` = 0), {`hi`,`lo`} at `done` equals the 64-bit unsigned product of the operands, with `hi` holding bits 63..32.
- R5: In signed mode (`signedMode` = 1), {`hi`,`lo`} at `done` equals the 64-bit two's-complement product of the operands.
- R6: A `start` seen while `busy` is high is ignored: the running result and the timing of `done` do not change.
- R7: While the block is idle and `start` is low, `hi` and `lo` hold their values.
- R8: The unsigned carry out of the adder is kept. 0xFFFFFFFF × 0xFFFFFFFF gives 0xFFFFFFFE_00000001.
- R9: Signed extremes are exact. -2^31 × -2^31 gives 0x40000000_00000000, and -2^31 × 1 gives 0xFFFFFFFF_80000000.
- R10: The recoding history bit is cleared at each accepted start, so a signed operation is correct even when the previous operation ended with a 1 shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| signedMode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| multiplicand | input | 32 | Operand added or subtracted on each step |
| multiplier | input | 32 | Operand loaded into the lower half of the product register |
| hi | output | 32 | Upper half of the product |
| lo | output | 32 | Lower half of the product |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |

## Verification
`busy` is due one cycle after the accepting edge, and `done`, the product and the fall of `busy` are due exactly 32 cycles after that edge. The bench drives inputs on falling edges and samples on falling edges. It checks that `done` stays low at each of the 31 intervening samples, that `done` is high at the 32nd, and that it is low again one sample later. The hold of the result while idle and the ignored mid-run start are checked on the samples just before and at that same `done` cycle.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture operands, clear upper half and history bit
    logic step;  // one add/subtract-and-shift iteration
  } mulCtl_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } stepOp_t;

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output mulCtl_t ctl,
  output logic    busy,
  output logic    done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic          busyQ;
  logic          doneQ;
  logic [CW-1:0] cntQ;

  always_comb begin
    ctl.load = start & ~busyQ;   // start while busy is dropped (R6)
    ctl.step = busyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      doneQ <= 1'b0;
      if (ctl.load) begin
        busyQ <= 1'b1;
        cntQ  <= '0;
      end else if (busyQ) begin
        cntQ <= cntQ + 1'b1;
        if (cntQ == LAST) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulCtl_t          ctl,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  localparam int PW = 2 * WIDTH;
  localparam int XW = WIDTH + 1;

  logic [PW-1:0]    prodQ;
  logic [WIDTH-1:0] mcandQ;
  logic             historyQ;
  logic             sgnQ;

  logic [WIDTH-1:0] upper;
  logic [XW-1:0]    upperX;
  logic [XW-1:0]    mcandX;
  logic [XW-1:0]    sumX;
  stepOp_t          op;

  always_comb begin
    upper  = prodQ[PW-1:WIDTH];
    upperX = {sgnQ & upper[WIDTH-1], upper};
    mcandX = {sgnQ & mcandQ[WIDTH-1], mcandQ};
    if (sgnQ) begin
      unique case ({prodQ[0], historyQ})
        2'b10:   op = OP_SUB;
        2'b01:   op = OP_ADD;
        default: op = OP_NONE;
      endcase
    end else begin
      op = prodQ[0] ? OP_ADD : OP_NONE;
    end
    unique case (op)
      OP_ADD:  sumX = upperX + mcandX;
      OP_SUB:  sumX = upperX - mcandX;
      default: sumX = upperX;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodQ    <= '0;
      mcandQ   <= '0;
      historyQ <= 1'b0;
      sgnQ     <= 1'b0;
    end else if (ctl.load) begin
      prodQ    <= {{WIDTH{1'b0}}, multiplier};
      mcandQ   <= multiplicand;
      historyQ <= 1'b0;
      sgnQ     <= signedMode;
    end else if (ctl.step) begin
      // extended sum becomes the top bits: carry in unsigned, sign in signed
      prodQ    <= {sumX, prodQ[WIDTH-1:1]};
      historyQ <= prodQ[0];
    end
  end

  assign hi = prodQ[PW-1:WIDTH];
  assign lo = prodQ[WIDTH-1:0];
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import shift_add_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo,
  output logic             busy,
  output logic             done
);
  mulCtl_t ctl;

  mul_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  mul_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .signedMode   (signedMode),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .hi           (hi),
    .lo           (lo)
  );
endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [WIDTH-1:0] hi,
  input logic [WIDTH-1:0] lo,
  input logic             busy,
  input logic             done
);
  localparam int CW = $clog2(WIDTH + 1) + 1;
  logic [CW-1:0] runCnt;

  // cycles since the accepting edge, kept independently of the control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              runCnt <= '0;
    else if (start && !busy) runCnt <= '0;
    else if (busy)          runCnt <= runCnt + 1'b1;
  end

  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r3_done_at_count: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runCnt == CW'(WIDTH)));

  a_r3_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && runCnt < CW'(WIDTH - 1)) |=> busy);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable({hi, lo}));
endmodule

bind shift_add_mul shift_add_mul_chk #(.WIDTH(WIDTH)) i_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .hi    (hi),
  .lo    (lo),
  .busy  (busy),
  .done  (done)
);

// File: tb/test_shift_add_mul.sv
`timescale 1ns/1ps
module test_shift_add_mul;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         signedMode = 1'b0;
  logic [W-1:0] multiplicand = '0;
  logic [W-1:0] multiplier = '0;
  logic [W-1:0] hi, lo;
  logic         busy, done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  shift_add_mul #(.WIDTH(W)) i_shift_add_mul (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .hi(hi), .lo(lo), .busy(busy), .done(done)
  );

  function automatic logic [63:0] expProd(input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic sgn);
    longint sa, sb;
    logic [63:0] ua, ub;
    if (sgn) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    ua = {32'b0, a};
    ub = {32'b0, b};
    return ua * ub;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One multiplication; poke = issue a second start mid-run (R6)
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic sgn, input bit poke, input string req);
    logic [63:0] exp;
    exp = expProd(a, b, sgn);
    @(negedge clk);
    start = 1'b1; signedMode = sgn; multiplicand = a; multiplier = b;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    for (int i = 2; i <= W; i++) begin
      if (poke && i == 10) begin
        start = 1'b1; signedMode = ~sgn; multiplicand = ~a; multiplier = b + 1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (done) check(1'b0, "R3 early done", 64'(i), 64'(W + 1));
    end
    start = 1'b0;
    @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R3 done timing", {62'b0, done, busy},
          64'd2);
    check({hi, lo} == exp, req, {hi, lo}, exp);
    @(negedge clk);
    check(done == 1'b0, "R3 done single cycle", 64'(done), 64'd0);
    check({hi, lo} == exp, "R7 hold while idle", {hi, lo}, exp);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && hi == 0 && lo == 0, "R1 reset state",
          {hi, lo}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    runOp(32'd6, 32'd7, 1'b0, 0, "R4 small unsigned");
    runOp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0, "R8 carry kept");
    runOp(32'h8000_0000, 32'h8000_0000, 1'b1, 0, "R9 min times min");
    runOp(32'h8000_0000, 32'd1, 1'b1, 0, "R9 min times one");
    runOp(32'hFFFF_FFFD, 32'd5, 1'b1, 0, "R5 negative times positive");
    runOp(32'd12345, 32'hFFFF_FF00, 1'b0, 1, "R6 start ignored while busy");
    // previous signed op ends with multiplier msb 1 shifted out
    runOp(32'd9, 32'h8000_0001, 1'b1, 0, "R5 setup for history");
    runOp(32'd3, 32'd2, 1'b1, 0, "R10 history cleared");
    runOp(32'd0, 32'hDEAD_BEEF, 1'b0, 0, "R4 zero operand");

    for (int n = 0; n < 200; n++) begin
      logic [W-1:0] a, b;
      logic s;
      a = $urandom();
      b = $urandom();
      s = $urandom() & 1;
      runOp(a, b, s, (n % 17) == 0, s ? "R5 random signed" : "R4 random unsigned");
    end

    // idle hold without start for several cycles (R7)
    begin
      logic [63:0] keep;
      keep = {hi, lo};
      multiplicand = 32'h1111_2222; multiplier = 32'h3333_4444;
      repeat (5) @(negedge clk);
      check({hi, lo} == keep, "R7 idle hold with new operands", {hi, lo}, keep);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule